// File: doc/BRIEF.md
# Dual-Drive PIO Cycle Timing Generator

This block times programmed-I/O transfers on a parallel disk cable shared by two drives, numbered 0 and 1. Each accepted access runs through three phases counted in bus clocks. First comes address setup. Next comes the active phase, where the read or write strobe is asserted. Last comes recovery. When recovery ends, the block reports completion and can accept the next access.

The timing comes from a configuration bank with five bytes. Each drive has two cycle bytes, one for reads and one for writes. The upper nibble of a cycle byte holds the strobe length minus one. The lower nibble holds the recovery length minus two. One shared miscellaneous byte carries three things:
- the address-setup length minus one, which firmware sets to the larger of the two drives' needs;
- a global read-prefetch enable;
- a ready-wait field.

A drive marked absent always runs with the smallest legal timing. The block copies the selected counts when it accepts a request, so rewriting the bank during an access does not change that access.

Top module: `pio_timing_gen`

## Requirements
- R1: While reset is asserted and after it is released with no request, busy, done, rd_strobe and wr_strobe are all low.
- R2: After acceptance, the setup phase lasts misc_cfg[5:4]+1 clocks (1 to 4). This value is the same for both drives, and no strobe is asserted during it.
- R3: The strobe phase lasts byte[7:4]+1 clocks (1 to 16). The byte is taken from set A for drive 0 (req_drive=0) and from set B for drive 1. Within the set, the read byte is used for reads (req_write=0) and the write byte for writes. The bytes that are not selected have no effect.
- R4: The recovery phase follows the strobe phase and lasts byte[3:0]+2 clocks (2 to 17), using the same byte as R3.
- R5: rd_strobe is asserted only during the strobe phase of a read, and wr_strobe only during the strobe phase of a write. The two strobes are never high together.
- R6: busy is high from the clock after acceptance through the last recovery clock. done is high for exactly that last recovery clock, once per access.
- R7: A request is taken only while busy is low. A request raised while busy is high is ignored, and busy falls after the current access.
- R8: The timing bytes and misc_cfg are sampled at acceptance. Changing them during an access does not change that access's phase lengths.
- R9: When drive_present is 0 for the selected drive, the access uses setup 1, strobe 1 and recovery 2, whatever the configuration bytes hold.
- R10: prefetch_en follows misc_cfg[6]. ready_wait equals misc_cfg[2:1]+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, taken while idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_drive | input | 1 | Target drive (0 or 1) |
| set_a_rd | input | 8 | Drive 0 read cycle byte |
| set_a_wr | input | 8 | Drive 0 write cycle byte |
| set_b_rd | input | 8 | Drive 1 read cycle byte |
| set_b_wr | input | 8 | Drive 1 write cycle byte |
| misc_cfg | input | 8 | Shared setup, prefetch and ready-wait byte |
| drive_present | input | 2 | Per-drive present flags |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| busy | output | 1 | An access is in progress |
| done | output | 1 | Last clock of the access |
| prefetch_en | output | 1 | Global read-prefetch enable |
| ready_wait | output | 3 | Ready-wait length in clocks |

## Verification
Some properties are checked by assertions on every clock:
- the strobes are never high together;
- a strobe only appears while busy;
- done marks the final busy clock and is never high with a strobe;
- each access starts in the setup phase with no strobe;
- an idle request always starts an access.

The bench's scenarios are needed for the rest:
- the exact phase lengths across all setup, strobe and recovery codes;
- the choice of set and byte by drive and direction;
- the absent-drive minimums;
- the ignored mid-access request and the unaffected timing when the bank is rewritten mid-access.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_ACT   = 2'd2,
    PH_REC   = 2'd3
  } phase_t;
endpackage

// File: rtl/pio_cfg_unpack.sv
module pio_cfg_unpack #(
  parameter int PULSE_W   = 4,
  parameter int REC_W     = 4,
  parameter int SETUP_W   = 2,
  parameter int SETUP_LSB = 4,
  parameter int CNT_W     = 5,
  localparam int BYTE_W   = PULSE_W + REC_W
) (
  input  logic              drive_sel,
  input  logic              is_write,
  input  logic [BYTE_W-1:0] a_rd,
  input  logic [BYTE_W-1:0] a_wr,
  input  logic [BYTE_W-1:0] b_rd,
  input  logic [BYTE_W-1:0] b_wr,
  input  logic [7:0]        misc,
  input  logic [1:0]        present,
  output logic [CNT_W-1:0]  setup_clks,
  output logic [CNT_W-1:0]  pulse_clks,
  output logic [CNT_W-1:0]  rec_clks
);
  logic [BYTE_W-1:0] cyc_byte;
  logic              drv_here;

  always_comb begin
    if (drive_sel) cyc_byte = is_write ? b_wr : b_rd;
    else           cyc_byte = is_write ? a_wr : a_rd;
    drv_here = present[drive_sel];
    if (drv_here) begin
      setup_clks = CNT_W'(misc[SETUP_LSB +: SETUP_W]) + CNT_W'(1);
      pulse_clks = CNT_W'(cyc_byte[REC_W +: PULSE_W]) + CNT_W'(1);
      rec_clks   = CNT_W'(cyc_byte[0 +: REC_W]) + CNT_W'(2);
    end else begin
      setup_clks = CNT_W'(1);
      pulse_clks = CNT_W'(1);
      rec_clks   = CNT_W'(2);
    end
  end

  always_comb begin
    assert_min_counts_R4: assert (pulse_clks >= CNT_W'(1) && rec_clks >= CNT_W'(2) && setup_clks >= CNT_W'(1))
      else $error("decoded count below minimum");
  end
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_timing_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [CNT_W-1:0] setup_in,
  input  logic [CNT_W-1:0] pulse_in,
  input  logic [CNT_W-1:0] rec_in,
  output logic             rd_strobe,
  output logic             wr_strobe,
  output logic             busy,
  output logic             done
);
  phase_t           ph_q, ph_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] pulse_q, rec_q;
  logic             wr_q;
  logic             take_en, last_clk;

  assign take_en  = (ph_q == PH_IDLE) && req_valid;
  assign last_clk = (cnt_q == CNT_W'(1));

  always_comb begin
    ph_n  = ph_q;
    cnt_n = cnt_q;
    unique case (ph_q)
      PH_IDLE: if (req_valid) begin
        ph_n  = PH_SETUP;
        cnt_n = setup_in;
      end
      PH_SETUP: if (last_clk) begin
        ph_n  = PH_ACT;
        cnt_n = pulse_q;
      end else cnt_n = cnt_q - CNT_W'(1);
      PH_ACT: if (last_clk) begin
        ph_n  = PH_REC;
        cnt_n = rec_q;
      end else cnt_n = cnt_q - CNT_W'(1);
      PH_REC: if (last_clk) begin
        ph_n  = PH_IDLE;
        cnt_n = '0;
      end else cnt_n = cnt_q - CNT_W'(1);
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
      rec_q   <= '0;
      wr_q    <= 1'b0;
    end else if (take_en) begin
      pulse_q <= pulse_in;
      rec_q   <= rec_in;
      wr_q    <= req_write;
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign rd_strobe = (ph_q == PH_ACT) && !wr_q;
  assign wr_strobe = (ph_q == PH_ACT) &&  wr_q;
  assign done      = (ph_q == PH_REC) && last_clk;

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe));
  assert_strobe_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe || wr_strobe) |-> busy);
  assert_done_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !rd_strobe && !wr_strobe));
  assert_hold_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  assert_setup_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!rd_strobe && !wr_strobe));
  assert_take_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);
endmodule

// File: rtl/pio_timing_gen.sv
module pio_timing_gen #(
  parameter int PULSE_W   = 4,
  parameter int REC_W     = 4,
  parameter int SETUP_W   = 2,
  parameter int SETUP_LSB = 4,
  parameter int PF_BIT    = 6,
  parameter int RDY_LSB   = 1,
  parameter int RDY_W     = 2,
  localparam int BYTE_W   = PULSE_W + REC_W,
  localparam int PW_N     = PULSE_W + 1,
  localparam int RW_N     = REC_W + 1,
  localparam int SW_N     = SETUP_W + 1,
  localparam int CW_A     = (PW_N > RW_N) ? PW_N : RW_N,
  localparam int CNT_W    = (CW_A > SW_N) ? CW_A : SW_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_drive,
  input  logic [BYTE_W-1:0] set_a_rd,
  input  logic [BYTE_W-1:0] set_a_wr,
  input  logic [BYTE_W-1:0] set_b_rd,
  input  logic [BYTE_W-1:0] set_b_wr,
  input  logic [7:0]        misc_cfg,
  input  logic [1:0]        drive_present,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic              busy,
  output logic              done,
  output logic              prefetch_en,
  output logic [RDY_W:0]    ready_wait
);
  logic [CNT_W-1:0] setup_c, pulse_c, rec_c;

  pio_cfg_unpack #(
    .PULSE_W(PULSE_W), .REC_W(REC_W), .SETUP_W(SETUP_W),
    .SETUP_LSB(SETUP_LSB), .CNT_W(CNT_W)
  ) unpack_i (
    .drive_sel(req_drive), .is_write(req_write),
    .a_rd(set_a_rd), .a_wr(set_a_wr), .b_rd(set_b_rd), .b_wr(set_b_wr),
    .misc(misc_cfg), .present(drive_present),
    .setup_clks(setup_c), .pulse_clks(pulse_c), .rec_clks(rec_c)
  );

  pio_phase_seq #(.CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .setup_in(setup_c), .pulse_in(pulse_c), .rec_in(rec_c),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .busy(busy), .done(done)
  );

  assign prefetch_en = misc_cfg[PF_BIT];
  assign ready_wait  = (RDY_W+1)'(misc_cfg[RDY_LSB +: RDY_W]) + (RDY_W+1)'(2);
endmodule

// File: tb/pio_timing_gen_tb.sv
module pio_timing_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_drive = 1'b0;
  logic [7:0] set_a_rd = '0, set_a_wr = '0, set_b_rd = '0, set_b_wr = '0, misc_cfg = '0;
  logic [1:0] drive_present = 2'b11;
  logic rd_strobe, wr_strobe, busy, done, prefetch_en;
  logic [2:0] ready_wait;
  int total = 0, bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pio_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_drive(req_drive), .set_a_rd(set_a_rd), .set_a_wr(set_a_wr),
    .set_b_rd(set_b_rd), .set_b_wr(set_b_wr), .misc_cfg(misc_cfg),
    .drive_present(drive_present), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .busy(busy), .done(done), .prefetch_en(prefetch_en), .ready_wait(ready_wait)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp=<190000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Program the four cycle bytes: the target gets tgt, the others its inverse.
  task automatic load_cfg(input bit d, input bit w, input logic [7:0] tgt);
    set_a_rd = ~tgt; set_a_wr = ~tgt; set_b_rd = ~tgt; set_b_wr = ~tgt;
    if (!d && !w) set_a_rd = tgt;
    if (!d &&  w) set_a_wr = tgt;
    if ( d && !w) set_b_rd = tgt;
    if ( d &&  w) set_b_wr = tgt;
  endtask

  task automatic run_txn(input bit d, input bit w, input int es, input int ep,
                         input int er, input bit scramble);
    int cyc = 0, first = 0, slen = 0, dcnt = 0, dat = 0, other = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_drive = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy && cyc < 100) begin
      cyc++;
      if (scramble && cyc == 1) begin
        set_a_rd = 8'hFF; set_a_wr = 8'hFF; set_b_rd = 8'hFF; set_b_wr = 8'hFF;
        misc_cfg = 8'h30; req_valid = 1'b1; req_write = ~w;
      end
      if (scramble && cyc == 2) req_valid = 1'b0;
      if (w ? wr_strobe : rd_strobe) begin
        if (first == 0) first = cyc;
        slen++;
      end
      if (w ? rd_strobe : wr_strobe) other++;
      if (done) begin dcnt++; dat = cyc; end
      @(negedge clk);
    end
    chk(cyc == es + ep + er, "R6 busy length", cyc, es + ep + er);
    chk(first == es + 1, "R2 setup length", first, es + 1);
    chk(slen == ep, "R3 strobe length", slen, ep);
    chk(cyc - first - slen + 1 == er, "R4 recovery length", cyc - first - slen + 1, er);
    chk(other == 0, "R5 wrong strobe", other, 0);
    chk(dcnt == 1 && dat == cyc, "R6 done position", dat, cyc);
    if (scramble) begin
      @(negedge clk);
      chk(!busy, "R7 busy request ignored", busy, 0);
    end
  endtask

  initial begin
    #5;
    chk(!busy && !done && !rd_strobe && !wr_strobe, "R1 in reset",
        {busy, done, rd_strobe, wr_strobe}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !rd_strobe && !wr_strobe, "R1 after reset",
        {busy, done, rd_strobe, wr_strobe}, 0);

    // Sweep every drive, direction, setup, strobe and recovery code.
    for (int d = 0; d < 2; d++)
      for (int w = 0; w < 2; w++)
        for (int s = 1; s <= 4; s++)
          for (int p = 1; p <= 16; p++)
            for (int r = 2; r <= 17; r++) begin
              load_cfg(d[0], w[0], {4'(p - 1), 4'(r - 2)});
              misc_cfg = {1'b0, 1'(p % 2), 2'(s - 1), 1'b0, 2'(r % 4), 1'b0};
              #1;
              chk(prefetch_en == 1'(p % 2), "R10 prefetch", prefetch_en, p % 2);
              chk(ready_wait == 3'((r % 4) + 2), "R10 ready wait", ready_wait, (r % 4) + 2);
              run_txn(d[0], w[0], s, p, r, 1'b0);
            end

    // Mid-access rewrite and busy request (R8, R7).
    for (int d = 0; d < 2; d++) begin
      load_cfg(d[0], 1'b0, 8'h21);
      misc_cfg = 8'h10;
      run_txn(d[0], 1'b0, 2, 3, 3, 1'b1);
    end

    // Absent drive uses minimum timing (R9).
    for (int d = 0; d < 2; d++) begin
      drive_present = d[0] ? 2'b01 : 2'b10;
      load_cfg(d[0], 1'b1, 8'hEE);
      misc_cfg = 8'h30;
      run_txn(d[0], 1'b1, 1, 1, 2, 1'b0);
    end
    drive_present = 2'b11;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule